// File: doc/BRIEF.md
# Masked-Pattern Output Router with Programmable Arbitration

This block sits on one output link of a multistage switch element; every output link has its own copy. Each input link presents a request line and a destination tag. The block decides whether a requesting input is headed for this output by comparing its tag against a small table of stored entries. Each entry holds a value, a care mask and an enable bit. Only the tag bits whose care bit is 1 are compared, so one entry covers a whole group of destinations. The table therefore grows with the number of switch stages, not with the number of destinations.

Among the inputs that hit an entry, one input is granted. Each input has a programmable rank, and the lowest rank wins. When ranks are equal, the lowest input index wins. The tag match is combinational and the grant is registered, so a decision takes one clock. Because the network is circuit switched, a grant stays with its input for as long as that input keeps its request high. Two write ports load table entries and input ranks.

Top module: `assoc_out_router`

## Requirements
- R1: After reset the grant is empty (`grant_o` = 0, `grant_vld_o` = 0), every table entry is disabled and every input rank is 0, so ties fall to the lowest input index.
- R2: Input i is a candidate only when `req_i[i]` is 1 and at least one enabled entry satisfies (tag & care) == (value & care), where a care bit of 1 means that tag bit is compared. A care mask of all zeros matches any tag.
- R3: An entry whose enable bit is 0 never produces a match, whatever its value and mask.
- R4: When the grant is free, the candidate with the numerically lowest rank is granted. Among equal ranks, the lowest input index is granted.
- R5: A grant appears on the outputs one clock edge after the matching request is presented at the inputs.
- R6: While the granted input keeps its request at 1, the grant stays on that input, even if a candidate with a better rank arrives or the table changes.
- R7: Once the granted input drops its request, the grant moves at the next edge to the current best candidate, or becomes empty if there is none.
- R8: A table or rank write presented at a clock edge first affects the grant decision made at the following edge.
- R9: `grant_o` is one-hot or zero, and `grant_idx_o` and `grant_vld_o` always agree with `grant_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_IN | Request line of each input link |
| tag_i | input | N_IN*TAG_W | Destination tag of each input; input i occupies bits [i*TAG_W +: TAG_W] |
| pat_we_i | input | 1 | Table entry write strobe |
| pat_idx_i | input | PIDX_W | Table entry to write |
| pat_val_i | input | TAG_W | Value to store in the entry |
| pat_care_i | input | TAG_W | Care mask to store (1 = bit compared) |
| pat_en_i | input | 1 | Enable bit to store in the entry |
| rank_we_i | input | 1 | Rank write strobe |
| rank_idx_i | input | IDX_W | Input whose rank is written |
| rank_val_i | input | RANK_W | New rank (lower value = higher priority) |
| grant_o | output | N_IN | One-hot grant vector |
| grant_vld_o | output | 1 | A grant is held |
| grant_idx_o | output | IDX_W | Index of the granted input |

## Verification
Directed cases separate the matching features. A disabled entry is tested against an exact tag, which shows whether the enable bit gates the match. A partial care mask is tested with one tag that differs only in a masked bit and another that differs in a compared bit. Equal ranks and then reprogrammed ranks show whether the index tie-break and the rank order each take effect. A better-ranked latecomer shows whether a held grant can be stolen. Constrained random traffic then biases tags toward the stored entries and flips requests and writes at random. This mixes free grants, holds, releases and same-cycle writes, and a bench model predicts each grant at the next edge.

// File: rtl/ar_pkg.sv
package ar_pkg;
   // Index width that stays at least one bit wide.
   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ar_pattern_store.sv
module ar_pattern_store #(
   parameter int TAG_W  = 6,
   parameter int N_PAT  = 4,
   parameter int PIDX_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic [PIDX_W-1:0]      idx_i,
   input  logic [TAG_W-1:0]       val_i,
   input  logic [TAG_W-1:0]       care_i,
   input  logic                   en_i,
   output logic [N_PAT*TAG_W-1:0] val_o,
   output logic [N_PAT*TAG_W-1:0] care_o,
   output logic [N_PAT-1:0]       en_o
);
   for (genvar p = 0; p < N_PAT; p++) begin : g_ent
      logic sel;
      assign sel = we_i && (idx_i == PIDX_W'(p));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_o[p*TAG_W +: TAG_W]  <= '0;
            care_o[p*TAG_W +: TAG_W] <= '0;
            en_o[p]                  <= 1'b0;
         end else if (sel) begin
            val_o[p*TAG_W +: TAG_W]  <= val_i;
            care_o[p*TAG_W +: TAG_W] <= care_i;
            en_o[p]                  <= en_i;
         end
      end
   end

   // R1
   reset_disables_chk: assert property (@(posedge clk)
      !rst_n |=> en_o == '0);
endmodule

// File: rtl/ar_tag_matcher.sv
module ar_tag_matcher #(
   parameter int TAG_W = 6,
   parameter int N_PAT = 4
) (
   input  logic                   req_i,
   input  logic [TAG_W-1:0]       tag_i,
   input  logic [N_PAT*TAG_W-1:0] val_i,
   input  logic [N_PAT*TAG_W-1:0] care_i,
   input  logic [N_PAT-1:0]       en_i,
   output logic                   hit_o
);
   logic [N_PAT-1:0] ent_hit;
   for (genvar p = 0; p < N_PAT; p++) begin : g_cmp
      assign ent_hit[p] = en_i[p] &&
         (((tag_i ^ val_i[p*TAG_W +: TAG_W]) & care_i[p*TAG_W +: TAG_W]) == '0);
   end
   assign hit_o = req_i && (|ent_hit);
endmodule

// File: rtl/ar_rank_arbiter.sv
module ar_rank_arbiter #(
   parameter int N_IN   = 4,
   parameter int RANK_W = 2,
   parameter int IDX_W  = 2
) (
   input  logic [N_IN-1:0]        cand_i,
   input  logic [N_IN*RANK_W-1:0] rank_i,
   output logic                   win_vld_o,
   output logic [IDX_W-1:0]       win_idx_o
);
   logic [RANK_W-1:0] best;
   always_comb begin
      win_vld_o = 1'b0;
      win_idx_o = '0;
      best      = '0;
      for (int i = 0; i < N_IN; i++) begin
         // strict compare keeps the lower index on equal rank
         if (cand_i[i] && (!win_vld_o || rank_i[i*RANK_W +: RANK_W] < best)) begin
            win_vld_o = 1'b1;
            win_idx_o = IDX_W'(i);
            best      = rank_i[i*RANK_W +: RANK_W];
         end
      end
   end
endmodule

// File: rtl/assoc_out_router.sv
module assoc_out_router #(
   parameter int N_IN   = 4,
   parameter int TAG_W  = 6,
   parameter int N_PAT  = 4,
   parameter int RANK_W = 2,
   parameter int IDX_W  = ar_pkg::idx_width(N_IN),
   parameter int PIDX_W = ar_pkg::idx_width(N_PAT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        req_i,
   input  logic [N_IN*TAG_W-1:0]  tag_i,
   input  logic                   pat_we_i,
   input  logic [PIDX_W-1:0]      pat_idx_i,
   input  logic [TAG_W-1:0]       pat_val_i,
   input  logic [TAG_W-1:0]       pat_care_i,
   input  logic                   pat_en_i,
   input  logic                   rank_we_i,
   input  logic [IDX_W-1:0]       rank_idx_i,
   input  logic [RANK_W-1:0]      rank_val_i,
   output logic [N_IN-1:0]        grant_o,
   output logic                   grant_vld_o,
   output logic [IDX_W-1:0]       grant_idx_o
);
   if (N_IN < 2)    begin : g_bad_nin  $error("N_IN must be at least 2"); end
   if (TAG_W < 1)   begin : g_bad_tag  $error("TAG_W must be positive"); end
   if (N_PAT < 1)   begin : g_bad_pat  $error("N_PAT must be positive"); end
   if (RANK_W < 1)  begin : g_bad_rank $error("RANK_W must be positive"); end
   if ((1 << IDX_W) < N_IN)   begin : g_bad_iw $error("IDX_W too narrow"); end
   if ((1 << PIDX_W) < N_PAT) begin : g_bad_pw $error("PIDX_W too narrow"); end

   logic [N_PAT*TAG_W-1:0] pv, pc;
   logic [N_PAT-1:0]       pe;
   logic [N_IN-1:0]        cand;
   logic [N_IN*RANK_W-1:0] ranks;
   logic                   win_vld;
   logic [IDX_W-1:0]       win_idx;
   logic                   held;

   ar_pattern_store #(.TAG_W(TAG_W), .N_PAT(N_PAT), .PIDX_W(PIDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we_i(pat_we_i), .idx_i(pat_idx_i),
      .val_i(pat_val_i), .care_i(pat_care_i), .en_i(pat_en_i),
      .val_o(pv), .care_o(pc), .en_o(pe));

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      ar_tag_matcher #(.TAG_W(TAG_W), .N_PAT(N_PAT)) u_match (
         .req_i(req_i[i]), .tag_i(tag_i[i*TAG_W +: TAG_W]),
         .val_i(pv), .care_i(pc), .en_i(pe), .hit_o(cand[i]));

      always_ff @(posedge clk) begin
         if (!rst_n)
            ranks[i*RANK_W +: RANK_W] <= '0;
         else if (rank_we_i && rank_idx_i == IDX_W'(i))
            ranks[i*RANK_W +: RANK_W] <= rank_val_i;
      end

      // R2
      cand_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cand[i] |-> req_i[i]);
   end

   ar_rank_arbiter #(.N_IN(N_IN), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_arb (
      .cand_i(cand), .rank_i(ranks), .win_vld_o(win_vld), .win_idx_o(win_idx));

   assign held = grant_vld_o && req_i[grant_idx_o];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_vld_o <= 1'b0;
         grant_idx_o <= '0;
      end else if (!held) begin
         grant_vld_o <= win_vld;
         grant_idx_o <= win_idx;
      end
   end

   always_comb begin
      grant_o = '0;
      if (grant_vld_o) grant_o[grant_idx_o] = 1'b1;
   end

   // R4
   winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> cand[win_idx]);
   // R6
   hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && req_i[grant_idx_o]) |=> (grant_vld_o && grant_idx_o == $past(grant_idx_o)));
   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && !req_i[grant_idx_o]) |=> !(grant_vld_o && grant_idx_o == $past(grant_idx_o)));
   // R5
   free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_vld_o |=> (grant_vld_o == $past(|cand)));
   // R9
   onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (grant_vld_o == (|grant_o)));
endmodule

// File: tb/assoc_out_router_tb_top.sv
module assoc_out_router_tb_top;
   localparam int N_IN = 4, TAG_W = 6, N_PAT = 4, RANK_W = 2, IDX_W = 2, PIDX_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_IN-1:0]       req = '0;
   logic [TAG_W-1:0]      tg [N_IN];
   logic [N_IN*TAG_W-1:0] tag_flat;
   logic                  pat_we = 1'b0, pat_en = 1'b0;
   logic [PIDX_W-1:0]     pat_idx = '0;
   logic [TAG_W-1:0]      pat_val = '0, pat_care = '0;
   logic                  rank_we = 1'b0;
   logic [IDX_W-1:0]      rank_idx = '0;
   logic [RANK_W-1:0]     rank_val = '0;
   logic [N_IN-1:0]       grant;
   logic                  grant_vld;
   logic [IDX_W-1:0]      grant_idx;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [TAG_W-1:0]  m_val [N_PAT];
   logic [TAG_W-1:0]  m_care[N_PAT];
   bit                m_en  [N_PAT];
   logic [RANK_W-1:0] m_rank[N_IN];
   bit                cur_vld = 0;
   int                cur_idx = 0;

   always #5 clk = ~clk;

   always_comb
      for (int i = 0; i < N_IN; i++) tag_flat[i*TAG_W +: TAG_W] = tg[i];

   assoc_out_router #(.N_IN(N_IN), .TAG_W(TAG_W), .N_PAT(N_PAT), .RANK_W(RANK_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .tag_i(tag_flat),
      .pat_we_i(pat_we), .pat_idx_i(pat_idx), .pat_val_i(pat_val),
      .pat_care_i(pat_care), .pat_en_i(pat_en),
      .rank_we_i(rank_we), .rank_idx_i(rank_idx), .rank_val_i(rank_val),
      .grant_o(grant), .grant_vld_o(grant_vld), .grant_idx_o(grant_idx));

   function automatic bit model_cand(int i);
      if (!req[i]) return 0;
      for (int p = 0; p < N_PAT; p++)
         if (m_en[p] && ((tg[i] ^ m_val[p]) & m_care[p]) == '0) return 1;
      return 0;
   endfunction

   function automatic logic [N_IN-1:0] vec_of(bit v, int idx);
      logic [N_IN-1:0] r = '0;
      if (v) r[idx] = 1'b1;
      return r;
   endfunction

   task automatic compare(string rq, bit ev, int ei);
      checks++;
      if (grant !== vec_of(ev, ei) || grant_vld !== ev || (ev && grant_idx !== IDX_W'(ei))) begin
         errors++;
         $display("FAIL %s grant=%b vld=%b idx=%0d expected grant=%b vld=%b idx=%0d",
                  rq, grant, grant_vld, grant_idx, vec_of(ev, ei), ev, ei);
      end
   endtask

   // inputs are set at a negedge; predict, apply model writes, advance, check
   task automatic step(string rq);
      bit nv = 0;
      int ni = 0;
      if (cur_vld && req[cur_idx]) begin
         nv = 1; ni = cur_idx;
      end else begin
         for (int i = 0; i < N_IN; i++)
            if (model_cand(i) && (!nv || m_rank[i] < m_rank[ni])) begin
               nv = 1; ni = i;
            end
      end
      if (pat_we) begin
         m_val[pat_idx] = pat_val; m_care[pat_idx] = pat_care; m_en[pat_idx] = pat_en;
      end
      if (rank_we) m_rank[rank_idx] = rank_val;
      @(posedge clk);
      cur_vld = nv; cur_idx = ni;
      @(negedge clk);
      pat_we = 0; rank_we = 0;
      compare(rq, cur_vld, cur_idx);
   endtask

   task automatic wr_pat(int p, logic [TAG_W-1:0] v, logic [TAG_W-1:0] c, bit e);
      pat_we = 1; pat_idx = PIDX_W'(p); pat_val = v; pat_care = c; pat_en = e;
   endtask

   task automatic wr_rank(int i, int r);
      rank_we = 1; rank_idx = IDX_W'(i); rank_val = RANK_W'(r);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < N_PAT; p++) begin m_val[p] = '0; m_care[p] = '0; m_en[p] = 0; end
      for (int i = 0; i < N_IN; i++) begin m_rank[i] = '0; tg[i] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      compare("R1 reset", 0, 0);

      // R3: disabled entry with exact value never matches
      wr_pat(0, 6'h2A, 6'h3F, 0); req = 4'b0001; tg[0] = 6'h2A;
      step("R3 disabled write");
      step("R3 disabled entry");
      // R8: enable written with request present; takes effect one edge later
      wr_pat(0, 6'h2A, 6'h3F, 1);
      step("R8 write not yet active");
      step("R2 R5 exact match grant");
      req = '0;
      step("R7 release to none");

      // R2: partial care mask (top two bits must be 01)
      wr_pat(1, 6'h10, 6'h30, 1);
      step("R8 entry1 load");
      req = 4'b1110; tg[1] = 6'h05; tg[2] = 6'h1F; tg[3] = 6'h13;
      step("R1 R4 equal rank lowest index wins");
      req = 4'b0010;
      step("R2 compared bit differs no match");
      tg[1] = 6'h1C; req = '0;
      step("R7 all dropped");

      wr_rank(2, 3);
      step("R8 rank load");
      wr_rank(3, 1);
      step("R8 rank load");
      req = 4'b1100;
      step("R4 lower rank beats lower index");
      req = 4'b1101; tg[0] = 6'h2A; wr_rank(0, 0);
      step("R6 better rank latecomer does not steal");
      wr_pat(1, 6'h00, 6'h3F, 0);
      step("R6 hold across table change");
      req = 4'b0101;
      step("R7 handover to best candidate");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         string lbl;
         for (int i = 0; i < N_IN; i++) begin
            if (($urandom % 4) == 0) req[i] = ~req[i];
            if (($urandom % 3) == 0) begin
               int p = $urandom % N_PAT;
               logic [TAG_W-1:0] rnd = TAG_W'($urandom);
               tg[i] = ($urandom % 2) ? ((m_val[p] & m_care[p]) | (rnd & ~m_care[p])) : rnd;
            end
         end
         if (($urandom % 12) == 0)
            wr_pat($urandom % N_PAT, TAG_W'($urandom), TAG_W'($urandom), ($urandom % 4) != 0);
         if (($urandom % 12) == 0) wr_rank($urandom % N_IN, $urandom % (1 << RANK_W));
         if (cur_vld && req[cur_idx]) lbl = "R6 random hold";
         else if (cur_vld)            lbl = "R7 random release";
         else                         lbl = "R4 random arbitration";
         step(lbl);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule